// File: doc/BRIEF.md
# SDRAM Bank Timing Guard

The guard watches the decoded command stream that a memory controller sends to a four-bank SDRAM. Each cycle it says, per bank and per command kind, whether that command may be issued now without breaking a minimum spacing rule. It also raises a sticky violation flag with a code the first time a command arrives whose ready signal is low. A command that arrives while its ready signal is low is refused: it leaves no trace in the guard's timers or bank state.

All limits are given as parameters in picoseconds and turned into whole clock cycles against a clock-period parameter. Minimum limits round up and the open-row maximum rounds down. The write-with-auto-precharge recovery is the sum of the write-recovery cycles and the precharge cycles, each rounded up on its own. A controller uses the ready outputs to schedule, and it treats the flag as proof that something in its scheduler has failed.

Top module: `sdram_timing_guard`

## Requirements
- R1: After reset every bank is closed, all `act_ok` and `pre_ok` bits and `pall_ok`, `ref_ok` and `mrs_ok` are 1, `col_ok` is 0 and `viol` is 0.
- R2: Once an activate is accepted at cycle t, the same bank may be activated again no earlier than t+RC cycles. Any other bank may be activated no earlier than t+RRD cycles. Activate is only ready on a closed bank.
- R3: A read or write to a bank is ready only while the bank is open, no earlier than RCD cycles after its activate, and no earlier than CCD cycles after the previous accepted read or write to any bank.
- R4: A precharge of an open bank is ready RAS cycles after its activate. It closes the bank, and the bank may then be activated no earlier than RP cycles later. Precharge of a closed bank is legal and has no effect. A precharge with `cmd_ap`=1 closes every open bank and is ready when every bank's precharge is ready.
- R5: A read with `cmd_ap`=1 closes its bank and allows the next activate of that bank RP cycles later. A write with `cmd_ap`=1 does the same after ceil(tWR/tCK)+ceil(tRP/tCK) cycles.
- R6: Refresh and mode-set are ready only when all banks are closed and no bank has an activate wait pending. After an accepted refresh, no bank may be activated for RFC cycles. After an accepted mode-set, no command is ready for MRD_CYC cycles.
- R7: Command encoding on `cmd_type`: 0 none, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, 6 mode-set, 7 treated as none. A command given with its ready signal low sets `viol` one cycle later with `viol_code` = {cmd_type, cmd_bank} and is refused. The flag and code keep the first event until reset.
- R8: A bank that is still open RASMAX cycles after its activate, with no command closing it in that cycle, sets `viol` one cycle later with `viol_code` = {3'd7, bank}.
- R9: Minimum limits convert as ceil(ps / CLK_PS) cycles and the open-row maximum as floor(ps / CLK_PS) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_vld | input | 1 | A command is present this cycle |
| cmd_type | input | 3 | Command kind (R7 encoding) |
| cmd_bank | input | 2 | Target bank |
| cmd_ap | input | 1 | Auto-precharge on read/write, all banks on precharge |
| act_ok | output | 4 | Activate ready, per bank |
| col_ok | output | 4 | Read or write ready, per bank |
| pre_ok | output | 4 | Precharge ready, per bank |
| pall_ok | output | 1 | Precharge of all banks ready |
| ref_ok | output | 1 | Refresh ready |
| mrs_ok | output | 1 | Mode-set ready |
| viol | output | 1 | Sticky violation flag |
| viol_code | output | 5 | Command kind and bank of the first violation |

## Verification
The assertions check on every cycle the properties that need no cycle count. The flag, once set, stays set and keeps its code. A refused activate produces the matching code. An accepted activate leaves its bank not ready for another activate. A mode-set blocks all commands in the next cycle. A ready read or write excludes refresh. The exact spacing values are shown only by the bench's scenarios: RC against RRD, RCD, RAS and RP, the write auto-precharge sum of separately rounded terms, the refresh recovery, and the exact cycle in which an open row overstays. The same goes for proof that a refused command left its bank untouched.

// File: rtl/sdt_pkg.sv
// Shared command encoding and cycle conversion for the SDRAM timing guard.
// Assumes limits are given in picoseconds and the clock period is nonzero.
package sdt_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5,
        CMD_MRS = 3'd6,
        CMD_AGE = 3'd7
    } sdt_cmd_e;

    // Round a minimum limit up to whole cycles, never below one cycle.
    function automatic int ps_to_cyc_up(input int unsigned ps, input int unsigned clk_ps);
        int unsigned c;
        c = (ps + clk_ps - 1) / clk_ps;
        return (c == 0) ? 1 : int'(c);
    endfunction

    // Round a maximum limit down to whole cycles.
    function automatic int ps_to_cyc_down(input int unsigned ps, input int unsigned clk_ps);
        return int'(ps / clk_ps);
    endfunction

endpackage

// File: rtl/sdt_gap_counter.sv
// Down-counter that holds off a command until a wait has elapsed.
// A load keeps the larger of the fresh wait and the wait still remaining,
// so several rules sharing one counter each keep their own minimum.
// Assumes load_val is the wanted gap minus one.
module sdt_gap_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         idle
);
    logic [W-1:0] cnt;
    logic [W-1:0] dec;

    // Remaining wait after this cycle, floored at zero.
    always_comb dec = (cnt == '0) ? '0 : cnt - W'(1);

    // Count down, or restart with the longer of the two waits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= (load_val > dec) ? load_val : dec;
        else
            cnt <= dec;
    end

    assign idle = (cnt == '0);
endmodule

// File: rtl/sdt_bank_track.sv
// State and timers of one bank: open/closed, the wait before the next
// activate, the wait before a column command, the wait before a precharge
// and the age of the open row. Assumes at most one command per cycle and
// that the caller passes only accepted commands.
module sdt_bank_track #(
    parameter int TW       = 5,
    parameter int AW       = 16,
    parameter int RC_C     = 9,
    parameter int RAS_C    = 6,
    parameter int RCD_C    = 3,
    parameter int RP_C     = 3,
    parameter int DAL_C    = 5,
    parameter int RFC_C    = 10,
    parameter int RASMAX_C = 16000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic do_act,
    input  logic do_rd,
    input  logic do_wr,
    input  logic do_pre,
    input  logic do_ref,
    input  logic ap,
    output logic is_open,
    output logic act_free,
    output logic col_free,
    output logic ras_free,
    output logic over_age
);
    logic          act_load;
    logic [TW-1:0] act_val;
    logic [AW-1:0] age;
    logic          closing;

    assign closing  = do_pre | ((do_rd | do_wr) & ap);
    assign act_load = do_act | closing | do_ref;

    // Pick the wait before the next activate from the command that starts it.
    always_comb begin
        if (do_act)
            act_val = TW'(RC_C - 1);
        else if (do_wr && ap)
            act_val = TW'(DAL_C - 1);
        else if (do_ref)
            act_val = TW'(RFC_C - 1);
        else
            act_val = TW'(RP_C - 1);
    end

    sdt_gap_counter #(.W(TW)) u_act_gap (
        .clk(clk), .rst_n(rst_n), .load(act_load), .load_val(act_val), .idle(act_free)
    );

    sdt_gap_counter #(.W(TW)) u_col_gap (
        .clk(clk), .rst_n(rst_n), .load(do_act), .load_val(TW'(RCD_C - 1)), .idle(col_free)
    );

    sdt_gap_counter #(.W(TW)) u_ras_gap (
        .clk(clk), .rst_n(rst_n), .load(do_act), .load_val(TW'(RAS_C - 1)), .idle(ras_free)
    );

    // Track whether a row is open in this bank.
    always_ff @(posedge clk) begin
        if (!rst_n)
            is_open <= 1'b0;
        else if (do_act)
            is_open <= 1'b1;
        else if (closing)
            is_open <= 1'b0;
    end

    // Count cycles since the activate, holding at the open-row limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            age <= '0;
        else if (do_act)
            age <= AW'(1);
        else if (is_open && age != AW'(RASMAX_C))
            age <= age + AW'(1);
    end

    assign over_age = is_open && (age == AW'(RASMAX_C));
endmodule

// File: rtl/sdram_timing_guard.sv
// Checks every command to a multi-bank SDRAM against its spacing rules,
// publishes per-bank ready signals, refuses illegal commands and records
// the first violation. Assumes one command per cycle, limits in ps.
module sdram_timing_guard
    import sdt_pkg::*;
#(
    parameter int NUM_BANKS    = 4,
    parameter int CLK_PS       = 7500,
    parameter int T_RC_PS      = 65000,
    parameter int T_RAS_PS     = 45000,
    parameter int T_RASMAX_PS  = 120000000,
    parameter int T_RCD_PS     = 20000,
    parameter int T_RP_PS      = 20000,
    parameter int T_RRD_PS     = 15000,
    parameter int T_WR_PS      = 15000,
    parameter int T_RFC_PS     = 75000,
    parameter int CCD_CYC      = 1,
    parameter int MRD_CYC      = 2,
    localparam int BW          = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_vld,
    input  logic [2:0]           cmd_type,
    input  logic [BW-1:0]        cmd_bank,
    input  logic                 cmd_ap,
    output logic [NUM_BANKS-1:0] act_ok,
    output logic [NUM_BANKS-1:0] col_ok,
    output logic [NUM_BANKS-1:0] pre_ok,
    output logic                 pall_ok,
    output logic                 ref_ok,
    output logic                 mrs_ok,
    output logic                 viol,
    output logic [BW+2:0]        viol_code
);
    localparam int RC_C     = ps_to_cyc_up(T_RC_PS, CLK_PS);
    localparam int RAS_C    = ps_to_cyc_up(T_RAS_PS, CLK_PS);
    localparam int RCD_C    = ps_to_cyc_up(T_RCD_PS, CLK_PS);
    localparam int RP_C     = ps_to_cyc_up(T_RP_PS, CLK_PS);
    localparam int RRD_C    = ps_to_cyc_up(T_RRD_PS, CLK_PS);
    localparam int WR_C     = ps_to_cyc_up(T_WR_PS, CLK_PS);
    localparam int RFC_C    = ps_to_cyc_up(T_RFC_PS, CLK_PS);
    localparam int DAL_C    = WR_C + RP_C;
    localparam int RASMAX_C = ps_to_cyc_down(T_RASMAX_PS, CLK_PS);
    localparam int TW       = $clog2(RC_C + RAS_C + RCD_C + DAL_C + RFC_C + RRD_C
                                     + CCD_CYC + MRD_CYC + 1);
    localparam int AW       = $clog2(RASMAX_C + 2);

    logic                 legal, go, bad;
    logic                 rrd_free, ccd_free, mrd_free;
    logic [NUM_BANKS-1:0] open_v, act_free_v, col_free_v, ras_free_v, age_v;
    logic [NUM_BANKS-1:0] hit_v;
    logic                 age_any;
    logic [BW-1:0]        age_bank;

    // Is the presented command allowed by its ready signal?
    always_comb begin
        case (cmd_type)
            CMD_ACT:        legal = act_ok[cmd_bank];
            CMD_RD, CMD_WR: legal = col_ok[cmd_bank];
            CMD_PRE:        legal = cmd_ap ? pall_ok : pre_ok[cmd_bank];
            CMD_REF:        legal = ref_ok;
            CMD_MRS:        legal = mrs_ok;
            default:        legal = 1'b1;
        endcase
    end

    assign go  = cmd_vld && legal;
    assign bad = cmd_vld && !legal;

    sdt_gap_counter #(.W(TW)) u_rrd_gap (
        .clk(clk), .rst_n(rst_n), .load(go && cmd_type == CMD_ACT),
        .load_val(TW'(RRD_C - 1)), .idle(rrd_free)
    );

    sdt_gap_counter #(.W(TW)) u_ccd_gap (
        .clk(clk), .rst_n(rst_n), .load(go && (cmd_type == CMD_RD || cmd_type == CMD_WR)),
        .load_val(TW'(CCD_CYC - 1)), .idle(ccd_free)
    );

    sdt_gap_counter #(.W(TW)) u_mrd_gap (
        .clk(clk), .rst_n(rst_n), .load(go && cmd_type == CMD_MRS),
        .load_val(TW'(MRD_CYC - 1)), .idle(mrd_free)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel, b_act, b_rd, b_wr, b_pre, b_close;

        assign sel     = (cmd_bank == BW'(b));
        assign b_act   = go && sel && cmd_type == CMD_ACT;
        assign b_rd    = go && sel && cmd_type == CMD_RD;
        assign b_wr    = go && sel && cmd_type == CMD_WR;
        assign b_pre   = go && cmd_type == CMD_PRE && (cmd_ap || sel) && open_v[b];
        assign b_close = b_pre || ((b_rd || b_wr) && cmd_ap);

        sdt_bank_track #(
            .TW(TW), .AW(AW), .RC_C(RC_C), .RAS_C(RAS_C), .RCD_C(RCD_C),
            .RP_C(RP_C), .DAL_C(DAL_C), .RFC_C(RFC_C), .RASMAX_C(RASMAX_C)
        ) u_track (
            .clk(clk), .rst_n(rst_n),
            .do_act(b_act), .do_rd(b_rd), .do_wr(b_wr), .do_pre(b_pre),
            .do_ref(go && cmd_type == CMD_REF), .ap(cmd_ap),
            .is_open(open_v[b]), .act_free(act_free_v[b]), .col_free(col_free_v[b]),
            .ras_free(ras_free_v[b]), .over_age(age_v[b])
        );

        assign act_ok[b] = !open_v[b] && act_free_v[b] && rrd_free && mrd_free;
        assign col_ok[b] = open_v[b] && col_free_v[b] && ccd_free && mrd_free;
        assign pre_ok[b] = (!open_v[b] || ras_free_v[b]) && mrd_free;
        assign hit_v[b]  = age_v[b] && !b_close;
    end

    assign pall_ok = &pre_ok;
    assign ref_ok  = mrd_free && ((open_v == '0) && (&act_free_v));
    assign mrs_ok  = ref_ok;

    // Lowest-numbered bank whose row has stayed open too long.
    always_comb begin
        age_any  = 1'b0;
        age_bank = '0;
        for (int i = NUM_BANKS - 1; i >= 0; i--) begin
            if (hit_v[i]) begin
                age_any  = 1'b1;
                age_bank = BW'(i);
            end
        end
    end

    // Capture the first violation; a refused command wins over an overstay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol      <= 1'b0;
            viol_code <= '0;
        end else if (!viol) begin
            if (bad) begin
                viol      <= 1'b1;
                viol_code <= {cmd_type, cmd_bank};
            end else if (age_any) begin
                viol      <= 1'b1;
                viol_code <= {CMD_AGE, age_bank};
            end
        end
    end
endmodule

// File: rtl/sdt_guard_checker.sv
// Temporal properties of the timing guard, attached by bind.
module sdt_guard_checker #(
    parameter int NUM_BANKS = 4,
    parameter int MRD_CYC   = 2,
    localparam int BW       = $clog2(NUM_BANKS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_vld,
    input logic [2:0]           cmd_type,
    input logic [BW-1:0]        cmd_bank,
    input logic [NUM_BANKS-1:0] act_ok,
    input logic [NUM_BANKS-1:0] col_ok,
    input logic                 ref_ok,
    input logic                 mrs_ok,
    input logic                 viol,
    input logic [BW+2:0]        viol_code
);
    // R7
    viol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> viol && $stable(viol_code));

    // R7
    viol_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld && !viol && cmd_type == 3'd1 && !act_ok[cmd_bank]
        |=> viol && viol_code == {3'd1, $past(cmd_bank)});

    // R2
    act_reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld && cmd_type == 3'd1 && act_ok[cmd_bank] |=> !act_ok[$past(cmd_bank)]);

    // R6
    mrs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (MRD_CYC > 1) && cmd_vld && cmd_type == 3'd6 && mrs_ok
        |=> act_ok == '0 && col_ok == '0 && !ref_ok && !mrs_ok);

    // R6
    col_vs_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_ok != '0) |-> !ref_ok && !mrs_ok);
endmodule

bind sdram_timing_guard sdt_guard_checker #(
    .NUM_BANKS(NUM_BANKS), .MRD_CYC(MRD_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_type(cmd_type),
    .cmd_bank(cmd_bank), .act_ok(act_ok), .col_ok(col_ok), .ref_ok(ref_ok),
    .mrs_ok(mrs_ok), .viol(viol), .viol_code(viol_code)
);

// File: tb/sdram_timing_guard_test.sv
`timescale 1ns/1ps
module sdram_timing_guard_test;
    localparam int NB     = 4;
    localparam int CLKP   = 5000;
    localparam int WR_PS  = 16000;
    localparam int RP_PS  = 18000;

    function automatic int cup(input int ps);
        return (ps + CLKP - 1) / CLKP;
    endfunction

    // R9: expected cycle counts, worked out from the picosecond limits
    localparam int E_RC   = cup(65000);
    localparam int E_RAS  = cup(45000);
    localparam int E_RCD  = cup(20000);
    localparam int E_RP   = cup(RP_PS);
    localparam int E_RRD  = cup(15000);
    localparam int E_DAL  = cup(WR_PS) + cup(RP_PS);
    localparam int E_RFC  = cup(75000);
    localparam int E_MRD  = 2;
    localparam int E_CCD  = 1;
    localparam int E_MAX  = 120000000 / CLKP;

    localparam int C_NOP = 0, C_ACT = 1, C_RD = 2, C_WR = 3, C_PRE = 4, C_REF = 5, C_MRS = 6;

    logic clk = 1'b0, rst_n = 1'b0, cmd_vld = 1'b0, cmd_ap = 1'b0;
    logic [2:0] cmd_type = 3'd0;
    logic [1:0] cmd_bank = 2'd0;
    logic [NB-1:0] act_ok, col_ok, pre_ok;
    logic pall_ok, ref_ok, mrs_ok, viol;
    logic [4:0] viol_code;

    always #2.5 clk = ~clk;

    sdram_timing_guard #(.CLK_PS(CLKP), .T_WR_PS(WR_PS), .T_RP_PS(RP_PS)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_type(cmd_type),
        .cmd_bank(cmd_bank), .cmd_ap(cmd_ap), .act_ok(act_ok), .col_ok(col_ok),
        .pre_ok(pre_ok), .pall_ok(pall_ok), .ref_ok(ref_ok), .mrs_ok(mrs_ok),
        .viol(viol), .viol_code(viol_code)
    );

    int tests = 0, fails = 0;
    int n = 0;
    int na[NB], nc[NB], np[NB], actat[NB];
    bit opn[NB];
    int nact, ncol, nmrd;
    bit ev;
    logic [4:0] ecode;

    task automatic chk(input bit ok, input string req, input logic [31:0] a, input logic [31:0] e);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, a, e);
        end
    endtask

    function automatic bit m_act(input int b);
        return !opn[b] && n >= na[b] && n >= nact && n >= nmrd;
    endfunction
    function automatic bit m_col(input int b);
        return opn[b] && n >= nc[b] && n >= ncol && n >= nmrd;
    endfunction
    function automatic bit m_pre(input int b);
        return (!opn[b] || n >= np[b]) && n >= nmrd;
    endfunction
    function automatic bit m_pall();
        bit r = 1'b1;
        for (int b = 0; b < NB; b++) r &= m_pre(b);
        return r;
    endfunction
    function automatic bit m_ref();
        bit r = (n >= nmrd);
        for (int b = 0; b < NB; b++) r &= !opn[b] && n >= na[b];
        return r;
    endfunction
    function automatic bit m_legal(input int t, input int b, input bit ap);
        case (t)
            C_ACT: return m_act(b);
            C_RD, C_WR: return m_col(b);
            C_PRE: return ap ? m_pall() : m_pre(b);
            C_REF, C_MRS: return m_ref();
            default: return 1'b1;
        endcase
    endfunction

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic m_reset();
        for (int b = 0; b < NB; b++) begin
            na[b] = 0; nc[b] = 0; np[b] = 0; actat[b] = 0; opn[b] = 1'b0;
        end
        nact = 0; ncol = 0; nmrd = 0; ev = 1'b0; ecode = '0;
    endtask

    task automatic m_apply(input int t, input int b, input bit ap);
        case (t)
            C_ACT: begin
                opn[b] = 1'b1; na[b] = n + E_RC; nc[b] = n + E_RCD;
                np[b] = n + E_RAS; nact = n + E_RRD; actat[b] = n;
            end
            C_RD, C_WR: begin
                ncol = n + E_CCD;
                if (ap) begin
                    opn[b] = 1'b0;
                    na[b] = mx(na[b], n + ((t == C_RD) ? E_RP : E_DAL));
                end
            end
            C_PRE: begin
                for (int k = 0; k < NB; k++)
                    if (opn[k] && (ap || k == b)) begin
                        opn[k] = 1'b0; na[k] = mx(na[k], n + E_RP);
                    end
            end
            C_REF: for (int k = 0; k < NB; k++) na[k] = mx(na[k], n + E_RFC);
            C_MRS: nmrd = n + E_MRD;
            default: ;
        endcase
    endtask

    // One cycle: compare outputs with the model, drive a command, advance.
    task automatic step(input int t, input int b, input bit ap);
        logic [NB-1:0] ea, ec, ep;
        bit leg;
        for (int k = 0; k < NB; k++) begin
            ea[k] = m_act(k); ec[k] = m_col(k); ep[k] = m_pre(k);
        end
        chk({act_ok, col_ok, pre_ok, pall_ok, ref_ok, mrs_ok} ==
            {ea, ec, ep, m_pall(), m_ref(), m_ref()},
            "R2 R3 R4 R5 R6 ready", {act_ok, col_ok, pre_ok, pall_ok, ref_ok, mrs_ok},
            {ea, ec, ep, m_pall(), m_ref(), m_ref()});
        chk({viol, viol_code} == {ev, ecode}, "R7 R8 flag", {viol, viol_code}, {ev, ecode});
        cmd_vld = (t != C_NOP); cmd_type = 3'(t); cmd_bank = 2'(b); cmd_ap = ap;
        leg = m_legal(t, b, ap);
        if (t != C_NOP) begin
            if (leg) m_apply(t, b, ap);
            else if (!ev) begin ev = 1'b1; ecode = {3'(t), 2'(b)}; end
        end
        if (!ev)
            for (int k = 0; k < NB; k++)
                if (!ev && opn[k] && (n - actat[k]) == E_MAX) begin
                    ev = 1'b1; ecode = {3'd7, 2'(k)};
                end
        @(posedge clk);
        n++;
        @(negedge clk);
        cmd_vld = 1'b0; cmd_type = 3'd0; cmd_ap = 1'b0;
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) step(C_NOP, 0, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cmd_vld = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_reset();
    endtask

    function automatic bit sig(input int s, input int b);
        case (s)
            0: return act_ok[b];
            1: return col_ok[b];
            2: return pre_ok[b];
            3: return ref_ok;
            default: return mrs_ok;
        endcase
    endfunction

    // Cycles from the last issued command until the selected ready rises.
    task automatic gap(input string req, input int s, input int b, input int e);
        int k = 1;
        while (!sig(s, b) && k < 30000) begin
            step(C_NOP, 0, 1'b0);
            k++;
        end
        chk(k == e, req, k, e);
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234abcd));
        do_reset();
        // R1: state out of reset
        chk({act_ok, col_ok, pre_ok, pall_ok, ref_ok, mrs_ok, viol} == {4'hF, 4'h0, 4'hF, 4'b1110},
            "R1 reset", {act_ok, col_ok, pre_ok, pall_ok, ref_ok, mrs_ok, viol},
            {4'hF, 4'h0, 4'hF, 4'b1110});

        // R2 R3 R4 R5 R6: random legal traffic against the model
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom_range(0, 99);
            int b = $urandom_range(0, NB - 1);
            bit ap = ($urandom_range(0, 3) == 0);
            int t = (r < 30) ? C_ACT : (r < 50) ? C_RD : (r < 65) ? C_WR :
                    (r < 78) ? C_PRE : (r < 83) ? C_REF : (r < 86) ? C_MRS : C_NOP;
            if (!m_legal(t, b, ap)) t = C_NOP;
            step(t, b, ap);
        end

        // R2: activate spacing, R4: precharge timing
        do_reset();
        step(C_ACT, 0, 1'b0);
        gap("R2 other-bank activate", 0, 1, E_RRD);
        do_reset();
        step(C_ACT, 0, 1'b0);
        gap("R4 activate to precharge", 2, 0, E_RAS);
        step(C_PRE, 0, 1'b0);
        gap("R2 same-bank activate", 0, 0, E_RC - E_RAS);
        step(C_ACT, 1, 1'b0);
        idle(20);
        step(C_PRE, 1, 1'b0);
        gap("R4 precharge to activate", 0, 1, E_RP);
        step(C_PRE, 2, 1'b0);
        chk(viol == 1'b0 && act_ok[2] == 1'b1, "R4 closed-bank precharge", {viol, act_ok[2]}, 2'b01);

        // R3: row to column and column to column
        step(C_ACT, 2, 1'b0);
        gap("R3 activate to column", 1, 2, E_RCD);
        step(C_RD, 2, 1'b0);
        gap("R3 column to column", 1, 2, E_CCD);

        // R5: write and read with auto-precharge
        do_reset();
        step(C_ACT, 3, 1'b0);
        idle(20);
        step(C_WR, 3, 1'b1);
        chk(col_ok[3] == 1'b0, "R5 write auto-precharge closes", col_ok[3], 1'b0);
        gap("R5 write auto-precharge recovery", 0, 3, E_DAL);
        step(C_ACT, 3, 1'b0);
        idle(20);
        step(C_RD, 3, 1'b1);
        gap("R5 read auto-precharge recovery", 0, 3, E_RP);

        // R4: precharge of all banks
        do_reset();
        step(C_ACT, 0, 1'b0);
        idle(E_RRD - 1);
        step(C_ACT, 1, 1'b0);
        chk(ref_ok == 1'b0, "R6 refresh blocked while open", ref_ok, 1'b0);
        idle(20);
        step(C_PRE, 3, 1'b1);
        chk(col_ok == 4'h0, "R4 all-bank precharge", col_ok, 4'h0);

        // R6: refresh and mode-set recovery
        do_reset();
        step(C_REF, 0, 1'b0);
        gap("R6 refresh to activate", 0, 0, E_RFC);
        step(C_MRS, 0, 1'b0);
        gap("R6 mode-set gap", 0, 2, E_MRD);

        // R7: refused command, first code kept, blocked, cleared by reset
        do_reset();
        step(C_ACT, 0, 1'b0);
        step(C_ACT, 1, 1'b0);
        chk({viol, viol_code} == {1'b1, 5'b00101}, "R7 code", {viol, viol_code}, {1'b1, 5'b00101});
        idle(4);
        chk(act_ok[1] == 1'b1, "R7 refused activate left bank closed", act_ok[1], 1'b1);
        step(C_RD, 3, 1'b0);
        chk(viol_code == 5'b00101, "R7 first code kept", viol_code, 5'b00101);
        do_reset();
        chk(viol == 1'b0, "R7 reset clears", viol, 1'b0);

        // R8: open-row limit, closed just in time then overstayed
        step(C_ACT, 1, 1'b0);
        idle(E_MAX - 1);
        step(C_PRE, 1, 1'b0);
        idle(2);
        chk(viol == 1'b0, "R8 close at limit", viol, 1'b0);
        step(C_ACT, 2, 1'b0);
        idle(E_MAX - 1);
        chk(viol == 1'b0, "R8 before limit", viol, 1'b0);
        step(C_NOP, 0, 1'b0);
        chk({viol, viol_code} == {1'b1, 5'b11110}, "R8 overstay", {viol, viol_code}, {1'b1, 5'b11110});

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule